// File: doc/BRIEF.md
# SONET Transmit Framing-Byte Inserter

This block sits on a single 8-bit STS-12 transmit lane. Each byte arrives on a valid/ready stream with a parity bit and a frame-pulse sideband. The block first checks the byte's parity. It then works out where the byte sits in the frame and, when overhead rewriting is enabled, replaces the framing bytes at the start of each frame with the A1 and A2 patterns. The result leaves on a second valid/ready stream, one register stage later. Each output byte carries a parity-error flag, a frame-start strobe and a realignment flag.

Frame timing comes only from the shared system frame pulse. In a real system this pulse fires once every 9720 bytes, which gives 8 kHz frames at 77.76 MHz. The pulse is sampled as a sideband of the input beat, so a pulse is seen only on a byte that is actually accepted. Between pulses the block's position counter runs on by itself, wrapping at the end of each frame.

Back-pressure rules are as follows. The block accepts an input byte when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds its value.

Top module: `sonet_tx_framer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. While the output is stalled, every output field stays stable.
- R3: A byte accepted in cycle n is presented on the output in cycle n+1, in input order, with nothing dropped or duplicated.
- R4: Parity is odd across the 8 data bits plus `in_par`. When the count of ones is even, `out_perr` is high on that byte's output beat.
- R5: An accepted byte with `in_fp` high is frame position 0. Its output beat has `out_sof` high.
- R6: Once the block has seen a frame pulse and `oh_en` is high, the block rewrites bytes by frame position:
  - positions 0 to 11 are output as 0xF6 (A1);
  - positions 12 to 23 are output as 0x28 (A2).
- R7: Bytes at positions 24 and above pass through unchanged.
- R8: A byte accepted with `oh_en` low passes through unchanged at any position, with the same latency.
- R9: With no pulse, the position wraps after FRAME_LEN accepted bytes. The next byte is position 0, with `out_sof` set and A1 inserted.
- R10: A pulse arriving while the expected position is not 0 realigns the position to 0 and sets `out_misalign` on that beat. A pulse at the expected position 0 leaves `out_misalign` low.
- R11: Before the first pulse after reset, no byte is rewritten and `out_sof` stays low.
- R12: `out_perr` reflects the input byte's parity even when that byte is replaced by a framing pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Transmit data byte |
| in_par | input | 1 | Odd parity bit for `in_data` |
| in_fp | input | 1 | System frame pulse, sampled with the beat |
| oh_en | input | 1 | Enables framing-byte rewriting, sampled with the beat |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte |
| out_perr | output | 1 | Parity error on this byte |
| out_sof | output | 1 | This byte is frame position 0 |
| out_misalign | output | 1 | Pulse realigned the frame on this byte |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:
- The A1 to A2 boundary between positions 11 and 12, and the A2 to payload boundary between positions 23 and 24. An off-by-one counter would show up there as one framing byte too many or too few.
- A pulse placed mid-frame. A design that ignored the pulse would keep inserting at the old phase. A design that flagged every pulse would raise `out_misalign` on correctly placed pulses.
- Frames with no pulse at all. These expose a counter that stops or wraps one byte late.
- Parity errors on bytes that are overwritten. These catch a check made on the rewritten byte.
- Random stalls on both sides. These reveal output fields that change under back-pressure and pipelines that drop or repeat beats.

// File: rtl/sonet_tx_framer_pkg.sv
package sonet_tx_framer_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       sof;
    logic       mis;
  } tx_beat_t;
endpackage

// File: rtl/tx_parity_chk.sv
module tx_parity_chk #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          err
);
  // odd parity: total count of ones including par must be odd
  assign err = ~(^{data, par});
endmodule

// File: rtl/tx_frame_pos.sv
module tx_frame_pos #(
  parameter int FRAME_LEN = 9720,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          fp,
  output logic [PW-1:0] cur_pos,
  output logic          locked,
  output logic          sof,
  output logic          misalign
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

  logic [PW-1:0] cnt_q;
  logic          lock_q;

  assign cur_pos  = fp ? '0 : cnt_q;
  assign locked   = lock_q | fp;
  assign sof      = locked && (cur_pos == '0);
  assign misalign = fp && lock_q && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (step) begin
      lock_q <= locked;
      if (!locked)             cnt_q <= '0;
      else if (cur_pos == LAST) cnt_q <= '0;
      else                     cnt_q <= cur_pos + 1'b1;
    end
  end

  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fp && lock_q && cnt_q == LAST) |=> (cnt_q == '0));

  p_fp_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fp) |=> (lock_q && cnt_q == PW'(1 % FRAME_LEN)));

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/tx_oh_overlay.sv
module tx_oh_overlay #(
  parameter int       DW    = 8,
  parameter int       N_A   = 12,
  parameter int       PW    = 14,
  parameter logic [7:0] A1_V = 8'hF6,
  parameter logic [7:0] A2_V = 8'h28
) (
  input  logic          en,
  input  logic          locked,
  input  logic [PW-1:0] pos,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam logic [PW-1:0] A1_END = PW'(N_A);
  localparam logic [PW-1:0] A2_END = PW'(2 * N_A);

  always_comb begin
    dout = din;
    if (en && locked) begin
      if (pos < A1_END)      dout = DW'(A1_V);
      else if (pos < A2_END) dout = DW'(A2_V);
    end
  end
endmodule

// File: rtl/sonet_tx_framer.sv
module sonet_tx_framer
  import sonet_tx_framer_pkg::*;
#(
  parameter int FRAME_LEN = 9720,
  parameter int N_A       = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_par,
  input  logic       in_fp,
  input  logic       oh_en,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_perr,
  output logic       out_sof,
  output logic       out_misalign
);
  localparam int PW = $clog2(FRAME_LEN);

  logic          step;
  logic          perr_c;
  logic [PW-1:0] pos_c;
  logic          lock_c, sof_c, mis_c;
  logic [7:0]    data_c;
  tx_beat_t      beat_q;
  logic          vld_q;

  assign in_ready = !vld_q || out_ready;
  assign step     = in_valid && in_ready;

  tx_parity_chk #(.DW(8)) u_par (
    .data(in_data), .par(in_par), .err(perr_c)
  );

  tx_frame_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(step), .fp(in_fp),
    .cur_pos(pos_c), .locked(lock_c), .sof(sof_c), .misalign(mis_c)
  );

  tx_oh_overlay #(.DW(8), .N_A(N_A), .PW(PW)) u_ovl (
    .en(oh_en), .locked(lock_c), .pos(pos_c), .din(in_data), .dout(data_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) beat_q <= '{data: data_c, perr: perr_c, sof: sof_c, mis: mis_c};
    end
  end

  assign out_valid    = vld_q;
  assign out_data     = beat_q.data;
  assign out_perr     = beat_q.perr;
  assign out_sof      = beat_q.sof;
  assign out_misalign = beat_q.mis;

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_perr)
                                   && $stable(out_sof) && $stable(out_misalign)));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_perr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(^{in_data, in_par})) |=> out_perr);

  p_mis_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_misalign) |-> out_sof);
endmodule

// File: tb/sonet_tx_framer_tb_top.sv
module sonet_tx_framer_tb_top;
  import sonet_tx_framer_pkg::*;

  localparam int L   = 48;
  localparam int NA  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_par = 1'b0, in_fp = 1'b0, oh_en = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_perr, out_sof, out_misalign;
  logic [7:0] out_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int ready_pct = 70;

  // behavioural model state
  bit m_lock = 0;
  int m_cnt  = 0;
  tx_beat_t expq[$];

  always #5 clk = ~clk;

  sonet_tx_framer #(.FRAME_LEN(L), .N_A(NA)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par(in_par), .in_fp(in_fp), .oh_en(oh_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_sof(out_sof), .out_misalign(out_misalign)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic tx_beat_t model(input logic [7:0] d, input logic p,
                                     input logic fp, input logic en, output string dtag);
    tx_beat_t b;
    int cur = fp ? 0 : m_cnt;
    bit lk  = m_lock || fp;
    b.mis  = fp && m_lock && (m_cnt != 0);
    b.sof  = lk && (cur == 0);
    b.perr = (^{d, p}) == 1'b0;
    b.data = d;
    if (!lk)          dtag = "R11";
    else if (!en)     dtag = "R8";
    else if (cur < NA) begin b.data = 8'hF6; dtag = (cur == 0 && !fp) ? "R9" : "R6"; end
    else if (cur < 2*NA) begin b.data = 8'h28; dtag = "R6"; end
    else              dtag = "R7";
    m_lock = lk;
    m_cnt  = lk ? ((cur == L-1) ? 0 : cur + 1) : 0;
    return b;
  endfunction

  string tagq[$];

  // one clock: compare at negedge, advance model at posedge
  task automatic tick();
    bit acc_in, acc_out;
    string t;
    tx_beat_t e;
    out_ready = ($urandom_range(99) < ready_pct);
    #1;
    chk(in_ready == (!out_valid || out_ready), "R2 in_ready", in_ready, !out_valid || out_ready);
    if (out_valid) begin
      if (expq.size() == 0) chk(0, "R3 unexpected beat", out_data, 0);
      else begin
        e = expq[0];
        chk(out_data == e.data, tagq[0], out_data, e.data);
        chk(out_perr == e.perr, "R4 R12 perr", out_perr, e.perr);
        chk(out_sof == e.sof, "R5 R9 sof", out_sof, e.sof);
        chk(out_misalign == e.mis, "R10 misalign", out_misalign, e.mis);
      end
    end
    acc_in  = in_valid && in_ready;
    acc_out = out_valid && out_ready;
    @(posedge clk);
    if (acc_out && expq.size() > 0) begin void'(expq.pop_front()); void'(tagq.pop_front()); end
    if (acc_in) begin
      e = model(in_data, in_par, in_fp, oh_en, t);
      expq.push_back(e);
      tagq.push_back({t, " data"});
    end
    @(negedge clk);
  endtask

  task automatic send(input bit fp, input bit en);
    logic [7:0] d = 8'($urandom);
    bit badp = ($urandom_range(9) == 0);
    while ($urandom_range(4) == 0) begin in_valid = 1'b0; tick(); end
    in_valid = 1'b1; in_data = d; in_fp = fp; oh_en = en;
    in_par = (~^d) ^ badp;
    do tick(); while (!(in_ready === 1'b1) && 0);
    // hold until accepted
    while (!dut_accepted) tick();
    in_valid = 1'b0; in_fp = 1'b0;
  endtask

  // tracks whether the most recent tick accepted the held beat
  bit dut_accepted;
  always @(posedge clk) dut_accepted <= in_valid && in_ready;

  task automatic frame(input int n, input bit fp_first, input bit en);
    for (int i = 0; i < n; i++) send(fp_first && i == 0, en);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: no pulse yet, enable high
    frame(30, 0, 1);
    // R5 R6 R7 R12: aligned frames with stalls
    frame(L, 1, 1);
    ready_pct = 40;
    frame(L, 1, 1);
    ready_pct = 100;
    frame(L, 1, 1);
    // R8: enable low
    ready_pct = 70;
    frame(L, 1, 0);
    // R9: flywheel, no pulse for two frames
    frame(2*L, 0, 1);
    // R10: pulse mid-frame at position 17
    frame(17, 1, 1);
    frame(L, 1, 1);
    frame(L, 1, 1);
    // drain
    ready_pct = 100;
    repeat (5) tick();
    chk(expq.size() == 0, "R3 drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule